// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block decides when a small microcontroller core may run again after it has gone into power-down. The core asks for power-down with a request input. The sequencer then turns the oscillator enable off and holds the CPU clock enable low. It watches two active-low pins: an external interrupt pin and a reset pin. Both pins pass through a two-flop synchronizer before their edges are detected. A falling edge on either pin turns the oscillator back on. The block then keeps the CPU clock gated until the clock source can be trusted.

There are two ways to time that gap. In timed mode, a start-up counter runs for a length picked by a 2-bit select. In pin-timed mode, the clock stays off for as long as the interrupt pin is held low. A wake-up from the reset pin always uses the counter. After the count, the block drives an internal reset. That reset lasts two cycles if the pin has already returned high. If the pin is still low, the reset lasts as long as the pin stays low, plus two cycles. A wake-up from the interrupt pin leaves an interrupt-pending flag for the core.

Top module: `pd_wake_seq`

## Requirements
- R1: When `rst_n` is released, the block is in the running state: `osc_en`=1, `cpu_clk_en`=1, `int_rst`=0 and `irq_pend`=0.
- R2: In the running state, `pd_req`=1 at a clock edge makes `osc_en` and `cpu_clk_en` read 0 right after that edge.
- R3: In power-down, a falling edge on `int_pin` or `rst_pin` sets `osc_en` to 1 at the third clock edge after the pin changes. Pin edges seen outside power-down have no effect on any output.
- R4: With `wake_sel`=0 and an interrupt wake-up, `cpu_clk_en` rises exactly N cycles after `osc_en`. N is 16 << (2*`dly_sel`), so select values 0, 1, 2 and 3 give 16, 64, 256 and 1024 cycles. An early return of the pin to high does not shorten this delay.
- R5: With `wake_sel`=1 and an interrupt wake-up, `cpu_clk_en` stays 0 for as long as `int_pin` is low, whatever N is. It rises at the third clock edge after the pin goes high.
- R6: `irq_pend` goes to 1 in the same cycle that `cpu_clk_en` returns after an interrupt wake-up. It holds that value until the next accepted power-down request, which clears it.
- R7: A reset-pin wake-up keeps `cpu_clk_en` at 0 for exactly N cycles after `osc_en` rises, in either `wake_sel` mode.
- R8: If `rst_pin` is back high well before the count ends, `int_rst` rises together with `cpu_clk_en` and stays high for exactly 2 cycles.
- R9: If `rst_pin` is still low when the count ends, `int_rst` stays 1 while the pin stays low. It falls at the fourth clock edge after the pin goes high.
- R10: If both pins fall in the same cycle, the block treats the event as a reset-pin wake-up, and `irq_pend` stays 0.
- R11: A `pd_req` pulse that arrives while the block is not in the running state is dropped. After the wake-up completes, the block stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pd_req | input | 1 | Power-down request from the core |
| wake_sel | input | 1 | 0: wake-up timed by the counter; 1: wake-up timed by the interrupt pin |
| int_pin | input | 1 | External interrupt pin, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active low, asynchronous |
| dly_sel | input | 2 | Start-up delay select (16/64/256/1024 cycles) |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Gate enable for the CPU clock |
| int_rst | output | 1 | Internal reset to the core |
| irq_pend | output | 1 | Interrupt pending after an interrupt wake-up |

## Verification
The hardest case to reach is a reset-pin wake-up where the pin's return to high races the end of the count. At that point the synchronizer delay decides between a two-cycle pulse and a held reset. The stimulus releases the pin a chosen number of cycles after the falling edge. It keeps that release either at least three cycles before the timeout or at least five cycles after it, and it predicts the exact length of `int_rst` from that offset. Random runs mix the two pins, both modes, all four delays and hold lengths longer than the count. A directed pulse on `pd_req` during start-up confirms that the request is not queued.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_PDOWN,
    ST_STARTUP,
    ST_PINWAIT,
    ST_RSTPULSE
  } pdw_state_e;

  // start-up length in cycles: 2^(base + step*sel)
  function automatic int unsigned pdw_len(input int unsigned sel,
                                          input int unsigned base_log,
                                          input int unsigned step_log);
    return 32'd1 << (base_log + step_log * sel);
  endfunction

endpackage

// File: rtl/pdw_pin_sync.sv
module pdw_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] shr;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shr  <= '1;
        last <= 1'b1;
      end else begin
        shr  <= {shr[STAGES-2:0], pin[i]};
        last <= shr[STAGES-1];
      end
    end

    assign lvl[i]  = shr[STAGES-1];
    assign fall[i] = last & ~shr[STAGES-1];
  end

endmodule

// File: rtl/pdw_startup_timer.sv
module pdw_startup_timer
  import pdw_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);

  localparam int MAX_LOG = BASE_LOG + STEP_LOG * ((1 << SEL_W) - 1);
  localparam int CW      = MAX_LOG + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = CW'(pdw_len(32'(sel), BASE_LOG, STEP_LOG) - 1);
  assign done  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (run && !done)  cnt <= cnt + CW'(1);
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done && !clr) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pdw_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             wake_sel,
  input  logic             int_pin,
  input  logic             rst_pin,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             int_rst,
  output logic             irq_pend
);

  localparam int IDX_INT = 0;
  localparam int IDX_RST = 1;

  logic [1:0] pin_lvl;
  logic [1:0] pin_fall;
  pdw_state_e state_q, state_d;
  logic by_rst_q, pulse_q, timer_done;
  logic pd_accept, wake_rst, wake_int, resume;

  pdw_pin_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({rst_pin, int_pin}),
    .lvl  (pin_lvl),
    .fall (pin_fall)
  );

  pdw_startup_timer #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_q != ST_STARTUP),
    .run  (state_q == ST_STARTUP),
    .sel  (dly_sel),
    .done (timer_done)
  );

  // named events
  assign pd_accept = (state_q == ST_RUN) && pd_req;
  assign wake_rst  = (state_q == ST_PDOWN) && pin_fall[IDX_RST];
  assign wake_int  = (state_q == ST_PDOWN) && pin_fall[IDX_INT] && !pin_fall[IDX_RST];
  assign resume    = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (pd_req) state_d = ST_PDOWN;
      ST_PDOWN: begin
        if (wake_rst)      state_d = ST_STARTUP;
        else if (wake_int) state_d = wake_sel ? ST_PINWAIT : ST_STARTUP;
      end
      ST_STARTUP:  if (timer_done) state_d = by_rst_q ? ST_RSTPULSE : ST_RUN;
      ST_PINWAIT:  if (pin_lvl[IDX_INT]) state_d = ST_RUN;
      ST_RSTPULSE: if (pin_lvl[IDX_RST] && pulse_q) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      by_rst_q <= 1'b0;
      pulse_q  <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_PDOWN) by_rst_q <= wake_rst;
      pulse_q <= (state_q == ST_RSTPULSE) && pin_lvl[IDX_RST];
      if (pd_accept)                irq_pend <= 1'b0;
      else if (resume && !by_rst_q) irq_pend <= 1'b1;
    end
  end

  assign osc_en     = (state_q != ST_PDOWN);
  assign cpu_clk_en = (state_q == ST_RUN) || (state_q == ST_RSTPULSE);
  assign int_rst    = (state_q == ST_RSTPULSE);

  // R2
  pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_accept |=> (!osc_en && !cpu_clk_en));

  // R3
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PDOWN) && !pin_fall[IDX_INT] && !pin_fall[IDX_RST]) |=> !osc_en);

  // R5
  pin_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PINWAIT) && !pin_lvl[IDX_INT]) |=> !cpu_clk_en);

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst && !pin_lvl[IDX_RST]) |=> int_rst);

  // R10
  rst_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> !by_rst_q);

endmodule

// File: tb/test_pd_wake_seq.sv
module test_pd_wake_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_req = 1'b0;
  logic       wake_sel = 1'b0;
  logic       int_pin = 1'b1;
  logic       rst_pin = 1'b1;
  logic [1:0] dly_sel = 2'd0;
  logic       osc_en, cpu_clk_en, int_rst, irq_pend;

  int checks = 0;
  int errors = 0;
  bit irq_exp = 1'b0;

  always #5 clk = ~clk;

  pd_wake_seq i_pd_wake_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .wake_sel  (wake_sel),
    .int_pin   (int_pin),
    .rst_pin   (rst_pin),
    .dly_sel   (dly_sel),
    .osc_en    (osc_en),
    .cpu_clk_en(cpu_clk_en),
    .int_rst   (int_rst),
    .irq_pend  (irq_pend)
  );

  function automatic int exp_len(input int sel);
    return 16 << (2 * sel);
  endfunction

  // expected int_rst length for a reset-pin wake released at cycle h
  function automatic int exp_rst_len(input int h, input int n);
    return (h <= n - 3) ? 2 : h - n + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // src: 0 interrupt pin, 1 reset pin, 2 both pins
  task automatic wake_run(input int src, input bit mode, input int sel, input int h, input bit poke);
    int n, t_osc, t_cpu, t_rst, rcnt;
    @(negedge clk);
    chk(irq_pend == irq_exp, "R6", irq_pend, irq_exp);
    dly_sel = 2'(sel);
    wake_sel = mode;
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    chk(!osc_en && !cpu_clk_en, "R2", {osc_en, cpu_clk_en}, 0);
    chk(!irq_pend, "R6", irq_pend, 0);
    repeat (3) @(negedge clk);
    chk(!osc_en, "R3", osc_en, 0);
    n = exp_len(sel);
    if (src != 1) int_pin = 1'b0;
    if (src != 0) rst_pin = 1'b0;
    t_osc = -1; t_cpu = -1; t_rst = -1; rcnt = 0;
    for (int g = 1; g < 5000; g++) begin
      @(negedge clk);
      if (osc_en && t_osc < 0) t_osc = g;
      if (cpu_clk_en && t_cpu < 0) t_cpu = g;
      if (int_rst && t_rst < 0) t_rst = g;
      rcnt += int'(int_rst);
      if (g == h) begin int_pin = 1'b1; rst_pin = 1'b1; end
      if (poke) pd_req = (g == 5);
      if (cpu_clk_en && !int_rst && g > h) break;
    end
    pd_req = 1'b0;
    chk(t_osc == 3, "R3", t_osc, 3);
    if (src == 0 && mode)
      chk(t_cpu == h + 3, "R5", t_cpu, h + 3);
    else if (src == 0)
      chk(t_cpu - t_osc == n, "R4", t_cpu - t_osc, n);
    else
      chk(t_cpu - t_osc == n, "R7", t_cpu - t_osc, n);
    if (src == 0) begin
      chk(rcnt == 0, "R4", rcnt, 0);
      chk(irq_pend == 1'b1, "R6", irq_pend, 1);
      irq_exp = 1'b1;
    end else begin
      chk(t_rst == t_cpu, "R8", t_rst, t_cpu);
      if (h <= n - 3) chk(rcnt == 2, "R8", rcnt, 2);
      else chk(rcnt == exp_rst_len(h, n), "R9", rcnt, exp_rst_len(h, n));
      chk(irq_pend == 1'b0, "R10", irq_pend, 0);
      irq_exp = 1'b0;
    end
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(osc_en && cpu_clk_en, "R11", {osc_en, cpu_clk_en}, 3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int src, sel, h, n;
    bit mode;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 state after reset
    chk(osc_en && cpu_clk_en && !int_rst && !irq_pend, "R1",
        {osc_en, cpu_clk_en, int_rst, irq_pend}, 4'b1100);

    // R3 pins ignored while running
    int_pin = 1'b0; rst_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk(osc_en && cpu_clk_en && !int_rst && !irq_pend, "R3",
        {osc_en, cpu_clk_en, int_rst, irq_pend}, 4'b1100);
    int_pin = 1'b1; rst_pin = 1'b1;
    repeat (5) @(negedge clk);

    wake_run(0, 1'b0, 0, 2, 1'b0);     // R4 early release
    wake_run(0, 1'b0, 2, 300, 1'b0);   // R4 long hold
    wake_run(0, 1'b1, 0, 100, 1'b0);   // R5 hold past the count
    wake_run(0, 1'b1, 3, 5, 1'b0);     // R5 short hold
    wake_run(1, 1'b0, 0, 4, 1'b0);     // R8 early release
    wake_run(1, 1'b1, 1, 90, 1'b0);    // R9 held reset
    wake_run(2, 1'b0, 0, 3, 1'b0);     // R10 both pins
    wake_run(2, 1'b1, 1, 80, 1'b0);    // R10 both, held
    wake_run(0, 1'b0, 1, 3, 1'b1);     // R11 request during start-up

    for (int it = 0; it < 30; it++) begin
      src  = int'($urandom % 3);
      mode = 1'($urandom % 2);
      sel  = int'($urandom % 4);
      n    = exp_len(sel);
      if (src == 0)
        h = 2 + int'($urandom % (2 * n));
      else if ($urandom % 2)
        h = 1 + int'($urandom % (n - 3));
      else
        h = n + 5 + int'($urandom % 40);
      wake_run(src, mode, sel, h, 1'b0);
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule